// File: doc/BRIEF.md
# Short Frame Sync Serial Transmitter

This block places one voice sample per frame onto a shared, time-multiplexed serial bus. The bus master supplies a transmit bit clock and a one-bit-wide frame sync pulse. Software or upstream logic writes the next sample into a holding register with a load strobe. When a valid short sync is seen, the block copies the holding register into a shift register, reports the copy with a one-cycle `taken` pulse, and shifts the word out MSB first. It enables its output driver only for that word's slot, which lets several devices share the line.

All logic runs on the system clock `clk`. The bit clock `bclk` is an input that is synchronous to `clk`, and the block finds its edges by comparing it with a registered copy. Every output reacts one `clk` cycle after the input edge that causes it. A "falling edge" or "rising edge" below means the `clk` cycle in which the block detects that change on `bclk`.

The block also classifies every sync pulse as short or long, so that a long pulse never starts a short-format slot. After reset or power-down, a start-up guard keeps the driver off for the first two sync pulses.

Top module: `sfs_tx`

## Requirements
- R1: While `rst_n` is low, and in the cycle after any cycle with `pdn` high, `sdo_oe` and `taken` are 0. `sdo` is 0 whenever `sdo_oe` is 0. Power-down clears the holding register, the start-up guard and the sync classification.
- R2: After reset or power-down, the first two sync pulses never enable the driver. The third and later pulses may enable it.
- R3: A sync pulse starts a slot if all of these hold:
  - a falling edge samples `fsync` high;
  - the previous falling edge sampled it low;
  - the guard has expired;
  - the previous pulse was short.
  On a start, `taken` is high in the following cycle. The driver turns on at the next rising edge, which presents the MSB.
- R4: With `mode`=0, bits 3 down to 0 of the word are sent, bit 3 first, one new bit on each rising edge. `sdo_oe` falls on the falling edge after the rising edge that presented bit 0, so the slot lasts three and a half bit periods.
- R5: With `mode`=1, bits 7 down to 0 are sent, bit 7 first. Bit 3 is held for a whole bit period, and bit 0 for half a period before the driver turns off at the next falling edge. `sdo` changes only on rising edges while the driver is on.
- R6: A pulse sampled high on two or more consecutive falling edges is long. The pulse that follows a long pulse never starts a slot. The first pulse after reset is treated the same way.
- R7: If `fsync` is still high on the first falling edge after a start, the slot is abandoned and `sdo_oe` falls at that edge.
- R8: The word sent is the value of the holding register at the start. A `load` after the start changes only the next frame's word.
- R9: A sync pulse that arrives while a word is still being shifted starts nothing and produces no `taken` pulse. The current word finishes unchanged.
- R10: `taken` is high for exactly one `clk` cycle per started slot, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdn | input | 1 | Synchronous power-down; clears all frame state |
| bclk | input | 1 | Transmit bit clock, synchronous to clk |
| fsync | input | 1 | Frame sync, sampled on bclk falling edges |
| mode | input | 1 | 0: 4-bit word, 1: 8-bit word |
| word_in | input | 8 | Parallel sample for the holding register |
| load | input | 1 | Writes word_in into the holding register |
| sdo | output | 1 | Serial data |
| sdo_oe | output | 1 | Driver enable for sdo (0 = high impedance) |
| taken | output | 1 | One-cycle pulse when the holding register is captured |

## Verification
Slots are driven with the following input patterns:
- one-edge sync pulses in both widths, which shows whether the enable opens on the right rising edge and closes in the middle of the LSB for each word length;
- pulses lasting two or three falling edges, which separate the abandon path from the following suppressed frame;
- the first two pulses after reset and after power-down, which expose a missing or too-short start-up guard;
- a short pulse injected in the middle of an 8-bit slot, and a load issued during a slot, which show whether in-flight data is protected.

Random words, widths and pulse lengths from a fixed seed mix these patterns in many orders.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

    // Word width selected by the mode input.
    typedef enum logic {
        SFS_NIBBLE = 1'b0,
        SFS_OCTET  = 1'b1
    } sfs_width_e;

    // Consecutive-high run length of the sync input, saturating.
    typedef enum logic [1:0] {
        RUN_NONE = 2'd0,
        RUN_ONE  = 2'd1,
        RUN_MANY = 2'd2
    } sfs_run_e;

endpackage

// File: rtl/sfs_bclk_edge.sv
module sfs_bclk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    output logic rise,
    output logic fall
);

    typedef struct packed {
        logic level;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.level = bclk;
        rise       = bclk & ~st_q.level;
        fall       = ~bclk & st_q.level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/sfs_sync_class.sv
module sfs_sync_class
    import sfs_pkg::*;
#(
    parameter int GUARD_FRAMES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pdn,
    input  logic fall,
    input  logic fsync,
    output logic start_req,
    output logic long_hit
);

    localparam int GUARD_W = $clog2(GUARD_FRAMES + 1);
    localparam logic [GUARD_W-1:0] GUARD_DONE = GUARD_W'(GUARD_FRAMES);

    typedef struct packed {
        logic               prev_hi;   // sync level at previous falling edge
        sfs_run_e           run;       // length of current/last high run
        logic               short_ok;  // last finished pulse was short
        logic [GUARD_W-1:0] guard;     // pulses seen since reset/power-down
    } cls_st_t;

    cls_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        start_req = 1'b0;
        long_hit  = 1'b0;
        if (fall) begin
            if (fsync) begin
                if (!st_q.prev_hi) begin
                    // leading falling edge of a new pulse
                    start_req = st_q.short_ok && (st_q.guard == GUARD_DONE);
                    st_d.run  = RUN_ONE;
                    if (st_q.guard != GUARD_DONE)
                        st_d.guard = st_q.guard + 1'b1;
                end else begin
                    // pulse seen high again: it is a long pulse
                    long_hit = 1'b1;
                    st_d.run = RUN_MANY;
                end
            end else begin
                if (st_q.prev_hi)
                    st_d.short_ok = (st_q.run == RUN_ONE);
                st_d.run = RUN_NONE;
            end
            st_d.prev_hi = fsync;
        end
        if (pdn) begin
            st_d      = '0;
            start_req = 1'b0;
            long_hit  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/sfs_shifter.sv
module sfs_shifter
    import sfs_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pdn,
    input  logic              rise,
    input  logic              fall,
    input  logic              start_req,
    input  logic              long_hit,
    input  logic              mode,
    input  logic [WORD_W-1:0] word_in,
    input  logic              load,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              taken
);

    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam int PAD_W = WORD_W - NIB_W;
    localparam logic [CNT_W-1:0] LEN_OCTET  = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] LEN_NIBBLE = CNT_W'(NIB_W);

    typedef struct packed {
        logic [WORD_W-1:0] hold;   // parallel holding register
        logic [WORD_W-1:0] sh;     // shift register, MSB leaves first
        logic [CNT_W-1:0]  left;   // bits still to present
        logic              busy;   // slot in progress
        logic              first;  // no falling edge since capture yet
        logic              oe;
        logic              dout;
        logic              taken;
    } sh_st_t;

    sh_st_t st_d, st_q;
    logic   finishing;
    logic   capture;
    sfs_width_e width;

    generate
        if (PAD_W > 0) begin : g_pad
            logic [WORD_W-1:0] nib_aligned;
            assign nib_aligned = {st_q.hold[NIB_W-1:0], {PAD_W{1'b0}}};
        end else begin : g_nopad
            logic [WORD_W-1:0] nib_aligned;
            assign nib_aligned = st_q.hold;
        end
    endgenerate

    logic [WORD_W-1:0] nib_word;
    generate
        if (PAD_W > 0) begin : g_sel_pad
            assign nib_word = g_pad.nib_aligned;
        end else begin : g_sel_nopad
            assign nib_word = g_nopad.nib_aligned;
        end
    endgenerate

    always_comb begin
        width     = sfs_width_e'(mode);
        st_d      = st_q;
        st_d.taken = 1'b0;
        finishing = fall && st_q.busy && st_q.oe && (st_q.left == '0);
        capture   = start_req && (!st_q.busy || finishing);

        if (load)
            st_d.hold = word_in;

        // release in the middle of the last bit
        if (finishing) begin
            st_d.oe   = 1'b0;
            st_d.busy = 1'b0;
            st_d.dout = 1'b0;
        end

        if (fall)
            st_d.first = 1'b0;

        // sync still high on the edge after capture: abandon the slot
        if (fall && st_q.first && long_hit) begin
            st_d.oe   = 1'b0;
            st_d.busy = 1'b0;
            st_d.left = '0;
            st_d.dout = 1'b0;
        end

        if (capture) begin
            st_d.busy  = 1'b1;
            st_d.first = 1'b1;
            st_d.taken = 1'b1;
            if (width == SFS_OCTET) begin
                st_d.sh   = st_q.hold;
                st_d.left = LEN_OCTET;
            end else begin
                st_d.sh   = nib_word;
                st_d.left = LEN_NIBBLE;
            end
        end

        // every rising edge presents the next bit
        if (rise && st_q.busy && (st_q.left != '0)) begin
            st_d.oe   = 1'b1;
            st_d.dout = st_q.sh[WORD_W-1];
            st_d.sh   = {st_q.sh[WORD_W-2:0], 1'b0};
            st_d.left = st_q.left - 1'b1;
        end

        if (pdn)
            st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sdo    = st_q.dout;
    assign sdo_oe = st_q.oe;
    assign taken  = st_q.taken;

endmodule

// File: rtl/sfs_tx.sv
module sfs_tx #(
    parameter int WORD_W       = 8,
    parameter int NIB_W        = 4,
    parameter int GUARD_FRAMES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pdn,
    input  logic              bclk,
    input  logic              fsync,
    input  logic              mode,
    input  logic [WORD_W-1:0] word_in,
    input  logic              load,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              taken
);

    logic rise, fall, start_req, long_hit;

    sfs_bclk_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .bclk  (bclk),
        .rise  (rise),
        .fall  (fall)
    );

    sfs_sync_class #(.GUARD_FRAMES(GUARD_FRAMES)) u_class (
        .clk       (clk),
        .rst_n     (rst_n),
        .pdn       (pdn),
        .fall      (fall),
        .fsync     (fsync),
        .start_req (start_req),
        .long_hit  (long_hit)
    );

    sfs_shifter #(.WORD_W(WORD_W), .NIB_W(NIB_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .pdn       (pdn),
        .rise      (rise),
        .fall      (fall),
        .start_req (start_req),
        .long_hit  (long_hit),
        .mode      (mode),
        .word_in   (word_in),
        .load      (load),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe),
        .taken     (taken)
    );

endmodule

// File: rtl/sfs_tx_checker.sv
module sfs_tx_checker (
    input logic clk,
    input logic rst_n,
    input logic pdn,
    input logic bclk,
    input logic fsync,
    input logic sdo,
    input logic sdo_oe,
    input logic taken
);

    logic [1:0] cyc_q;
    logic       warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cyc_q <= '0;
        else if (cyc_q != 2'd3)  cyc_q <= cyc_q + 2'd1;
    end
    assign warm = (cyc_q == 2'd3);

    p_pdn_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pdn |=> (!sdo_oe && !taken));

    p_sdo_low_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe |-> !sdo);

    p_oe_opens_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $rose(sdo_oe)) |-> ($past(bclk) && !$past(bclk, 2)));

    p_taken_after_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && taken) |-> ($past(fsync) && !$past(bclk) && $past(bclk, 2)));

    p_oe_closes_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $fell(sdo_oe)) |-> ((!$past(bclk) && $past(bclk, 2)) || $past(pdn)));

    p_sdo_moves_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && sdo_oe && $past(sdo_oe) && !($past(bclk) && !$past(bclk, 2)))
            |-> $stable(sdo));

    p_taken_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> !taken);

endmodule

bind sfs_tx sfs_tx_checker u_sfs_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .pdn    (pdn),
    .bclk   (bclk),
    .fsync  (fsync),
    .sdo    (sdo),
    .sdo_oe (sdo_oe),
    .taken  (taken)
);

// File: tb/tb_sfs_tx.sv
module tb_sfs_tx;
    localparam int W = 8;
    localparam int P = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0, pdn = 1'b0, bclk = 1'b1, fsync = 1'b0, mode = 1'b0, load = 1'b0;
    logic [W-1:0] word_in = '0;
    logic sdo, sdo_oe, taken;

    int checks = 0, failures = 0, taken_seen = 0;
    logic [W-1:0] m_hold = '0;
    int m_guard = 0;
    bit m_short = 1'b0;
    logic s_oe, s_sdo;

    sfs_tx dut (
        .clk(clk), .rst_n(rst_n), .pdn(pdn), .bclk(bclk), .fsync(fsync),
        .mode(mode), .word_in(word_in), .load(load),
        .sdo(sdo), .sdo_oe(sdo_oe), .taken(taken)
    );

    always #2 clk = ~clk;

    always @(negedge clk) if (taken) taken_seen++;

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [W-1:0] exp_word(input bit m, input logic [W-1:0] w);
        return m ? w : {4'b0, w[3:0]};
    endfunction

    function automatic logic [2*P-1:0] exp_oe(input bit s, input bit ab, input int n);
        logic [2*P-1:0] v = '0;
        for (int p = 0; p < P; p++) begin
            v[p]     = s && !ab && p >= 1 && p <= n - 1;
            v[P + p] = s && (ab ? (p == 0) : (p < n));
        end
        return v;
    endfunction

    // one half bit period: 4 clk cycles, outputs sampled one cycle after the edge
    task automatic bhalf(input logic b, input logic fs, input bit do_load, input logic [W-1:0] nw);
        @(negedge clk); bclk = b; fsync = fs;
        @(negedge clk); s_oe = sdo_oe; s_sdo = sdo;
        @(negedge clk); if (do_load) begin word_in = nw; load = 1'b1; end
        @(negedge clk); load = 1'b0;
    endtask

    task automatic preload(input logic [W-1:0] w);
        @(negedge clk); word_in = w; load = 1'b1;
        @(negedge clk); load = 1'b0;
        m_hold = w;
    endtask

    task automatic frame(input bit m, input int slen, input bit mid, input bit ldmid,
                         input logic [W-1:0] nw, input string tag);
        int n = m ? 8 : 4;
        bit s, ab, mid_eff;
        logic [2*P-1:0] got = '0;
        logic [W-1:0] got_b = '0, used;
        int t0;
        mode = m;
        s = m_short && (m_guard >= 2);
        ab = s && (slen > 1);
        mid_eff = mid && s && m && (slen == 1);
        used = m_hold;
        if (m_guard < 2) m_guard++;
        m_short = (slen == 1);
        t0 = taken_seen;
        for (int p = 0; p < P; p++) begin
            bhalf(1'b0, (p < slen) || (mid_eff && p == 3), 1'b0, '0);
            got[p] = s_oe;
            bhalf(1'b1, fsync, ldmid && p == 2, nw);
            got[P + p] = s_oe;
            if (p < n) got_b = {got_b[W-2:0], s_sdo};
        end
        if (mid_eff) begin
            if (m_guard < 2) m_guard++;
            m_short = 1'b1;
        end
        if (ldmid) m_hold = nw;
        check(got == exp_oe(s, ab, n), {tag, " R3 enable window"}, int'(got), int'(exp_oe(s, ab, n)));
        if (s && !ab)
            check(got_b == exp_word(m, used), m ? "R5 octet bits" : "R4 nibble bits",
                  int'(got_b), int'(exp_word(m, used)));
        check((taken_seen - t0) == int'(s), {tag, " R10 taken count"}, taken_seen - t0, int'(s));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        check(sdo_oe == 1'b0 && taken == 1'b0 && sdo == 1'b0, "R1 reset state",
              {sdo_oe, taken, sdo}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(sdo_oe == 1'b0 && taken == 1'b0, "R1 after reset", {sdo_oe, taken}, 0);

        preload(8'hA5);
        frame(1'b0, 1, 0, 0, '0, "R2 guard pulse 1");
        frame(1'b0, 1, 0, 0, '0, "R2 guard pulse 2");
        frame(1'b0, 1, 0, 0, '0, "R4 first nibble");
        preload(8'h3C);
        frame(1'b1, 1, 0, 0, '0, "R5 octet");
        preload(8'h81);
        frame(1'b1, 2, 0, 0, '0, "R7 long pulse abandons");
        frame(1'b0, 1, 0, 0, '0, "R6 after long");
        frame(1'b0, 1, 0, 0, '0, "R6 recovered");
        preload(8'h96);
        frame(1'b1, 1, 1, 0, '0, "R9 sync mid slot");
        preload(8'h5A);
        frame(1'b1, 1, 0, 1, 8'hC3, "R8 load mid slot");
        frame(1'b1, 1, 0, 0, '0, "R8 next frame word");

        @(negedge clk); pdn = 1'b1;
        repeat (6) @(negedge clk);
        check(sdo_oe == 1'b0 && taken == 1'b0 && sdo == 1'b0, "R1 power-down quiet",
              {sdo_oe, taken, sdo}, 0);
        pdn = 1'b0;
        m_guard = 0; m_short = 1'b0; m_hold = '0;
        preload(8'hE7);
        frame(1'b0, 1, 0, 0, '0, "R2 post-pdn pulse 1");
        frame(1'b0, 1, 0, 0, '0, "R2 post-pdn pulse 2");
        frame(1'b0, 1, 0, 0, '0, "R2 post-pdn drive");

        for (int i = 0; i < 60; i++) begin
            int sl;
            sl = ($urandom % 5 == 0) ? 2 + int'($urandom % 2) : 1;
            if ($urandom % 2) preload(W'($urandom));
            frame(1'($urandom), sl, 1'($urandom % 4 == 0), 1'($urandom % 4 == 0),
                  W'($urandom), "R6 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule